// File: doc/BRIEF.md
# Power-Control Bus Master

This block lets a host processor run single read or write transactions against power-control slaves on a management bus. The host sees four 32-bit registers: a command/status word, a write-data word, a timeout word and a read-data word. To write, the host loads the write-data register first. It then writes the command word with the start bit set, along with the slave address, the word offset and the operation flag. To read, the host writes the command in the same way and collects the result from the read-data register once the transaction has finished.

On the slave side the block drives a parallel request/acknowledge port. A request stays asserted until the slave acknowledges or until the programmed cycle budget runs out. The acknowledge may carry an error flag. The host detects completion by polling for the start bit to clear. It then inspects two separate status bits, one for a slave error and one for a timeout.

Top module: `pmbm_master`

## Requirements
- R1: After reset all four host registers read zero and the slave request is low.
- R2: The host address selects a register by its bits 3:2: 0 is the command word, 1 is write data, 2 is timeout, 3 is read data. Writing the command word while idle with bit 31 (start) set starts a transaction. On the next cycle the request is high and carries these values: the operation from command bit 20 (1 = write, 0 = read), the slave address from bits 19:12, the word offset from bits 11:0 and the write-data register. While the transaction is open, command bit 31 (start) and bit 28 (busy) both read 1.
- R3: An acknowledge seen while the request is high ends the transaction on that clock edge. From the next cycle the request is low and start and busy read 0.
- R4: The read-data register loads the slave read data only when a read is acknowledged without error. Writes, errored reads and timed-out reads leave it unchanged.
- R5: An acknowledge with the error flag set leaves command bit 29 (slave error) at 1 and bit 30 (timeout) at 0.
- R6: If no acknowledge arrives, the request stays high for exactly T cycles and the transaction then ends with bit 30 set. T is the timeout register value, and a value of 0 counts as 1. An acknowledge in any of those T cycles wins.
- R7: A command word written while busy is ignored. The open request and the stored command fields are unchanged, and no further transaction follows.
- R8: A command write that starts a transaction clears both error bits.
- R9: The write-data and timeout registers read back what was written. Command bits 27:21 read zero.
- R10: Write data is captured when the transaction starts. Rewriting the write-data register during a transaction does not change the data presented to the slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data of the addressed register |
| slv_req | output | 1 | Transaction request to slave |
| slv_we | output | 1 | 1 = write, 0 = read |
| slv_addr | output | 8 | Slave address |
| slv_off | output | 12 | Register word offset |
| slv_wdata | output | 32 | Data to write |
| slv_rdata | input | 32 | Data returned by slave |
| slv_ack | input | 1 | Slave acknowledge |
| slv_err | input | 1 | Slave error, valid with acknowledge |

## Verification
The assertions assume the slave raises its acknowledge only while the request is high. They also assume the error flag has meaning only alongside that acknowledge. The bench's slave model drives the acknowledge only in a cycle where it has seen the request high, and drops it, with the error flag, on the next cycle. The sweep covers every timeout budget from 0 to 6 against every acknowledge delay from 0 to 7, so both sides of the timeout boundary are hit, including the case where the acknowledge lands in the last cycle of the budget.

// File: rtl/pmbm_pkg.sv
package pmbm_pkg;
    localparam int REG_W    = 32;
    localparam int SADDR_W  = 8;
    localparam int OFF_W    = 12;
    localparam int BIT_GO   = 31;
    localparam int BIT_TMO  = 30;
    localparam int BIT_SERR = 29;
    localparam int BIT_BUSY = 28;
    localparam int BIT_WE   = 20;
    localparam int SADDR_LO = 12;

    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_WDAT = 2'd1;
    localparam logic [1:0] SEL_TMO  = 2'd2;
    localparam logic [1:0] SEL_RDAT = 2'd3;

    typedef enum logic {ST_IDLE, ST_WAIT} seq_state_e;
endpackage

// File: rtl/pmbm_timer.sv
module pmbm_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] limit,
    input  logic             run,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] lim;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t q, d;
    logic [CNT_W:0] eff;
    logic [CNT_W:0] next_cnt;

    always_comb begin
        eff      = (q.lim == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, q.lim};
        next_cnt = {1'b0, q.cnt} + 1'b1;
        expire   = run && (next_cnt >= eff);
        d = q;
        if (load) begin
            d.lim = limit;
            d.cnt = '0;
        end else if (run && !expire) begin
            d.cnt = next_cnt[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6: the wait counter never reaches the budget while a request is open
    p_count_in_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ({1'b0, q.cnt} < eff));
endmodule

// File: rtl/pmbm_seq.sv
module pmbm_seq
    import pmbm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic               launch_we,
    input  logic [SADDR_W-1:0] launch_addr,
    input  logic [OFF_W-1:0]   launch_off,
    input  logic [REG_W-1:0]   launch_wdata,
    input  logic               expire,
    input  logic               slv_ack,
    input  logic               slv_err,
    input  logic [REG_W-1:0]   slv_rdata,
    output logic               busy,
    output logic               slv_req,
    output logic               slv_we,
    output logic [SADDR_W-1:0] slv_addr,
    output logic [OFF_W-1:0]   slv_off,
    output logic [REG_W-1:0]   slv_wdata,
    output logic               fin_ok,
    output logic               fin_err,
    output logic               fin_tmo,
    output logic               rd_load,
    output logic [REG_W-1:0]   rd_data
);
    typedef struct packed {
        seq_state_e         st;
        logic               we;
        logic [SADDR_W-1:0] addr;
        logic [OFF_W-1:0]   off;
        logic [REG_W-1:0]   wdata;
    } seq_t;

    seq_t q, d;

    always_comb begin
        busy      = (q.st == ST_WAIT);
        slv_req   = busy;
        slv_we    = q.we;
        slv_addr  = q.addr;
        slv_off   = q.off;
        slv_wdata = q.wdata;
        fin_ok    = busy && slv_ack && !slv_err;
        fin_err   = busy && slv_ack && slv_err;
        fin_tmo   = busy && !slv_ack && expire;
        rd_load   = fin_ok && !q.we;
        rd_data   = slv_rdata;
        d = q;
        case (q.st)
            ST_IDLE: if (launch) begin
                d.st    = ST_WAIT;
                d.we    = launch_we;
                d.addr  = launch_addr;
                d.off   = launch_off;
                d.wdata = launch_wdata;
            end
            ST_WAIT: if (slv_ack || expire) d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    // R7 / R10: an unanswered, unexpired request holds all its fields
    p_hold_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_req && !slv_ack && !expire) |=> (slv_req && $stable(slv_addr) &&
        $stable(slv_off) && $stable(slv_we) && $stable(slv_wdata)));

    // R3: acknowledge closes the request on the next cycle
    p_ack_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_req && slv_ack) |=> !slv_req);
endmodule

// File: rtl/pmbm_master.sv
module pmbm_master
    import pmbm_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [3:0]         host_addr,
    input  logic [REG_W-1:0]   host_wdata,
    output logic [REG_W-1:0]   host_rdata,
    output logic               slv_req,
    output logic               slv_we,
    output logic [SADDR_W-1:0] slv_addr,
    output logic [OFF_W-1:0]   slv_off,
    output logic [REG_W-1:0]   slv_wdata,
    input  logic [REG_W-1:0]   slv_rdata,
    input  logic               slv_ack,
    input  logic               slv_err
);
    localparam int RSV_W = BIT_BUSY - BIT_WE - 1;

    typedef struct packed {
        logic               we;
        logic [SADDR_W-1:0] addr;
        logic [OFF_W-1:0]   off;
        logic               tmo_flag;
        logic               serr_flag;
        logic [REG_W-1:0]   wdata;
        logic [TMO_W-1:0]   tmo;
        logic [REG_W-1:0]   rdata;
    } regs_t;

    regs_t q, d;
    logic [1:0] sel;
    logic cmd_wr, accept, launch, busy, expire;
    logic fin_ok, fin_err, fin_tmo, rd_load;
    logic [REG_W-1:0] rd_data;

    pmbm_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .launch(launch),
        .launch_we(host_wdata[BIT_WE]),
        .launch_addr(host_wdata[SADDR_LO +: SADDR_W]),
        .launch_off(host_wdata[OFF_W-1:0]),
        .launch_wdata(q.wdata),
        .expire(expire),
        .slv_ack(slv_ack), .slv_err(slv_err), .slv_rdata(slv_rdata),
        .busy(busy),
        .slv_req(slv_req), .slv_we(slv_we), .slv_addr(slv_addr),
        .slv_off(slv_off), .slv_wdata(slv_wdata),
        .fin_ok(fin_ok), .fin_err(fin_err), .fin_tmo(fin_tmo),
        .rd_load(rd_load), .rd_data(rd_data)
    );

    pmbm_timer #(.CNT_W(TMO_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(launch),
        .limit(q.tmo),
        .run(busy),
        .expire(expire)
    );

    always_comb begin
        sel    = host_addr[3:2];
        cmd_wr = host_wr && (sel == SEL_CMD);
        accept = cmd_wr && !busy;
        launch = accept && host_wdata[BIT_GO];
        d = q;
        if (accept) begin
            d.we   = host_wdata[BIT_WE];
            d.addr = host_wdata[SADDR_LO +: SADDR_W];
            d.off  = host_wdata[OFF_W-1:0];
        end
        if (launch) begin
            d.tmo_flag  = 1'b0;
            d.serr_flag = 1'b0;
        end
        if (host_wr && sel == SEL_WDAT) d.wdata = host_wdata;
        if (host_wr && sel == SEL_TMO)  d.tmo   = host_wdata[TMO_W-1:0];
        if (fin_tmo) d.tmo_flag  = 1'b1;
        if (fin_err) d.serr_flag = 1'b1;
        if (rd_load) d.rdata = rd_data;

        case (sel)
            SEL_CMD:  host_rdata = {busy, q.tmo_flag, q.serr_flag, busy,
                                    {RSV_W{1'b0}}, q.we, q.addr, q.off};
            SEL_WDAT: host_rdata = q.wdata;
            SEL_TMO:  host_rdata = {{(REG_W-TMO_W){1'b0}}, q.tmo};
            default:  host_rdata = q.rdata;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2: a start command issued while idle raises the request next cycle
    p_start_raises_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr[3:2] == SEL_CMD && host_wdata[BIT_GO] && !slv_req)
        |=> slv_req);

    // R8: starting a transaction leaves both error flags clear
    p_start_clears_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr[3:2] == SEL_CMD && host_wdata[BIT_GO] && !slv_req)
        |=> (!q.tmo_flag && !q.serr_flag));

    // R4: read data only moves on a clean read acknowledge
    p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(slv_req && slv_ack && !slv_err && !slv_we) |=> $stable(q.rdata));

    // R5 / R6: a transaction ends one way only
    p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.tmo_flag && q.serr_flag));
endmodule

// File: tb/pmbm_master_tb.sv
module pmbm_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = 4'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [31:0] host_rdata;
    logic        slv_req, slv_we;
    logic [7:0]  slv_addr;
    logic [11:0] slv_off;
    logic [31:0] slv_wdata;
    logic [31:0] slv_rdata = 32'd0;
    logic        slv_ack = 1'b0;
    logic        slv_err = 1'b0;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pmbm_master u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .slv_req(slv_req), .slv_we(slv_we), .slv_addr(slv_addr),
        .slv_off(slv_off), .slv_wdata(slv_wdata),
        .slv_rdata(slv_rdata), .slv_ack(slv_ack), .slv_err(slv_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [3:0] a, output logic [31:0] v);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    function automatic logic [31:0] mkcmd(input bit go, input bit we,
                                          input logic [7:0] a, input logic [11:0] o);
        return {go, 10'd0, we, a, o};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp_rd;
        exp_rd = 32'd0;
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            hread(4'(i * 4), v);
            chk(v == 32'd0, "R1", v, 32'd0);
        end
        chk(slv_req == 1'b0, "R1", {31'd0, slv_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep timeout budget against acknowledge delay
        for (int t = 0; t < 7; t++) begin
            for (int dl = 0; dl < 8; dl++) begin
                int teff, cyc, expc;
                bit we, e, succ, fin;
                logic [7:0]  sa;
                logic [11:0] so;
                logic [31:0] wd, rp, expcmd;
                teff = (t == 0) ? 1 : t;
                we   = dl[0];
                e    = ((t + dl) % 3) == 0;
                sa   = 8'((t * 37 + dl * 11) & 8'hff);
                so   = 12'((t * 100 + dl * 7) & 12'hfff);
                wd   = 32'hA500_0000 ^ {16'd0, 8'(t), 8'(dl)};
                rp   = 32'h5A5A_0000 | {24'd0, 4'(t), 4'(dl)};
                succ = dl < teff;
                expc = succ ? dl + 1 : teff;

                hwrite(4'h8, 32'(t));
                hwrite(4'h4, wd);
                hwrite(4'h0, mkcmd(1'b1, we, sa, so));
                // R2: request fields
                chk(slv_req == 1'b1, "R2", {31'd0, slv_req}, 32'd1);
                chk(slv_addr == sa && slv_off == so && slv_we == we, "R2",
                    {11'd0, slv_we, slv_addr, slv_off}, {11'd0, we, sa, so});
                if (we) chk(slv_wdata == wd, "R2", slv_wdata, wd);
                hread(4'h0, v);
                // R8: flags cleared, start and busy high
                chk(v[31:28] == 4'b1001, "R8", {28'd0, v[31:28]}, 32'h9);

                cyc = 0; fin = 1'b0;
                while (!fin && cyc < 40) begin
                    if (!slv_req) fin = 1'b1;
                    else begin
                        cyc++;
                        if (cyc - 1 == dl) begin
                            slv_ack = 1'b1; slv_err = e; slv_rdata = rp;
                            @(negedge clk);
                            slv_ack = 1'b0; slv_err = 1'b0;
                            fin = 1'b1;
                        end else begin
                            @(negedge clk);
                        end
                    end
                end
                // R6: request length against budget
                chk(cyc == expc, "R6", 32'(cyc), 32'(expc));
                // R3: closed
                chk(slv_req == 1'b0, "R3", {31'd0, slv_req}, 32'd0);
                if (succ && !we && !e) exp_rd = rp;
                expcmd = {1'b0, !succ, succ && e, 1'b0, 7'd0, we, sa, so};
                hread(4'h0, v);
                chk(v == expcmd, succ ? "R5" : "R6", v, expcmd);
                hread(4'hC, v);
                chk(v == exp_rd, "R4", v, exp_rd);
            end
        end

        // R9: timeout and write-data readback
        hwrite(4'h8, 32'd10);
        hread(4'h8, v);
        chk(v == 32'd10, "R9", v, 32'd10);

        // R10: write data captured at start
        hwrite(4'h4, 32'h0000_1234);
        hwrite(4'h0, mkcmd(1'b1, 1'b1, 8'h21, 12'h042));
        hwrite(4'h4, 32'h0000_FFFF);
        chk(slv_wdata == 32'h0000_1234, "R10", slv_wdata, 32'h0000_1234);
        hread(4'h4, v);
        chk(v == 32'h0000_FFFF, "R9", v, 32'h0000_FFFF);
        slv_ack = 1'b1;
        @(negedge clk);
        slv_ack = 1'b0;

        // R7: command while busy ignored
        hwrite(4'h0, mkcmd(1'b1, 1'b0, 8'h11, 12'h022));
        hwrite(4'h0, mkcmd(1'b1, 1'b1, 8'h99, 12'h0AB));
        chk(slv_req && slv_addr == 8'h11 && slv_off == 12'h022 && !slv_we, "R7",
            {11'd0, slv_we, slv_addr, slv_off}, {11'd0, 1'b0, 8'h11, 12'h022});
        slv_ack = 1'b1; slv_rdata = 32'hCAFE_0001;
        @(negedge clk);
        slv_ack = 1'b0;
        @(negedge clk);
        chk(slv_req == 1'b0, "R7", {31'd0, slv_req}, 32'd0);
        hread(4'h0, v);
        chk(v == mkcmd(1'b0, 1'b0, 8'h11, 12'h022), "R7", v,
            mkcmd(1'b0, 1'b0, 8'h11, 12'h022));
        // R9: reserved bits read zero
        chk(v[27:21] == 7'd0, "R9", {25'd0, v[27:21]}, 32'd0);
        hread(4'hC, v);
        chk(v == 32'hCAFE_0001, "R4", v, 32'hCAFE_0001);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule